// File: doc/BRIEF.md
# Immediate Logic and Shift Execution Unit

This unit performs one register-immediate operation per accepted request on a 32-bit data operand. The operations are AND, OR, bit test, arithmetic right shift, logical right shift and arithmetic left shift. Each request carries a 10-bit instruction field that holds a 2-bit register index and an 8-bit immediate. It also carries the current register value, read from an external register file, and the current status word. The unit returns the new register value, a write enable for the indexed register and the updated status word.

Each operation changes its own subset of the zero, negative, carry and overflow flags. Bit test computes flags only and requests no write. A small two-state machine controls the output stage. It has the states `S_IDLE` (no result on the outputs) and `S_EMIT` (a result is presented for one cycle). The transition `accept` leads from either state to `S_EMIT` when a request with a legal operation code arrives. The transition `drain` leads from either state to `S_IDLE` in every other cycle.

Top module: `imm_alu_unit`

## Requirements
- R1: `in_insn[9:8]` selects the destination register index, which appears on `out_idx`. `in_insn[7:0]` is the immediate. The operation codes on `in_op` are AND=0, OR=1, bit test=2, arithmetic right shift=3, logical right shift=4, arithmetic left shift=5.
- R2: AND and OR combine the operand with the immediate zero-extended to 32 bits, write the result, and assert `out_we`.
- R3: AND, OR and bit test set zero (status bit 0) when the 32-bit result is 0, copy result bit 31 into negative (status bit 1), and clear carry (status bit 2) and overflow (status bit 3).
- R4: Bit test computes its flags from operand AND immediate, deasserts `out_we`, and presents the unchanged operand on `out_data`.
- R5: The two right shifts move the operand right by the immediate amount. The arithmetic shift fills vacated bits with bit 31 and the logical shift fills them with 0. Both set carry to operand bit 0 as it was before the shift, set zero and negative from the result, keep overflow, and write the result.
- R6: The left shift moves the operand left by the immediate amount with zero fill, updates only zero and negative from the result, keeps carry and overflow, and writes the result.
- R7: A shift amount of 32 or more gives 0 for the left shift and the logical right shift, and 32 copies of bit 31 for the arithmetic right shift. A shift amount of 0 leaves the value unchanged but still updates the flags as given in R5 and R6.
- R8: Results, index, write enable and status appear together in the cycle after an accepted request, with `out_valid` high for exactly that cycle.
- R9: Status bits 7:4 pass from `in_stat` to `out_stat` unchanged for every operation.
- R10: Requests with operation codes 6 or 7 are ignored: `out_valid` and `out_we` stay low and the data outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_insn | input | 10 | Register index (9:8) and immediate (7:0) |
| in_opnd | input | 32 | Current value of the indexed register |
| in_stat | input | 8 | Current status word |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| out_idx | output | 2 | Destination register index |
| out_data | output | 32 | New register value |
| out_we | output | 1 | Register write enable |
| out_stat | output | 8 | New status word |

## Verification
The corners that are hardest to reach are the arithmetic right shift of a negative operand by 32 or more, and a shift by 0 whose carry comes from an odd operand. Uniform random immediates rarely hit amounts of exactly 0, 31 or 32, and random operands give both sign values only half the time. The stimulus therefore adds directed requests at these amounts with negative and odd operands. It also sends back-to-back requests and illegal codes between legal ones, to check that results stay aligned with their requests and that the outputs hold when a request is ignored.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 8;
    localparam int IDX_W  = 2;
    localparam int STAT_W = 8;

    localparam int FLG_Z = 0;
    localparam int FLG_N = 1;
    localparam int FLG_C = 2;
    localparam int FLG_V = 3;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_TST = 3'd2,
        OP_SRA = 3'd3,
        OP_SRL = 3'd4,
        OP_SLA = 3'd5
    } alu_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } emit_state_e;
endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
    import imm_alu_pkg::*;
#(
    parameter int P_IMM_W = IMM_W,
    parameter int P_IDX_W = IDX_W
) (
    input  logic [P_IDX_W+P_IMM_W-1:0] insn,
    input  logic [2:0]                 op_raw,
    output logic [P_IDX_W-1:0]         idx,
    output logic [P_IMM_W-1:0]         imm,
    output logic                       legal
);
    localparam int INSN_W = P_IDX_W + P_IMM_W;

    always_comb begin
        idx   = insn[INSN_W-1:P_IMM_W];
        imm   = insn[P_IMM_W-1:0];
        legal = (op_raw <= 3'd5);
    end
endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
    import imm_alu_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_IMM_W  = IMM_W,
    parameter int P_STAT_W = STAT_W
) (
    input  logic [2:0]          op,
    input  logic [P_IMM_W-1:0]  imm,
    input  logic [P_DATA_W-1:0] opnd,
    input  logic [P_STAT_W-1:0] stat_in,
    output logic [P_DATA_W-1:0] result,
    output logic                we,
    output logic [P_STAT_W-1:0] stat_out
);
    localparam int SH_W = $clog2(P_DATA_W);

    logic [P_DATA_W-1:0] imm_ext;
    logic [P_DATA_W-1:0] sra_v, srl_v, sla_v;
    logic [P_DATA_W-1:0] flag_src;
    logic                big_amt;
    logic [SH_W-1:0]     sh;

    always_comb begin
        imm_ext = {{(P_DATA_W-P_IMM_W){1'b0}}, imm};
        big_amt = (32'(imm) >= 32'(P_DATA_W));
        sh      = imm[SH_W-1:0];
        sra_v   = big_amt ? {P_DATA_W{opnd[P_DATA_W-1]}}
                          : P_DATA_W'($signed(opnd) >>> sh);
        srl_v   = big_amt ? '0 : (opnd >> sh);
        sla_v   = big_amt ? '0 : (opnd << sh);
    end

    always_comb begin
        result   = opnd;
        we       = 1'b1;
        stat_out = stat_in;
        flag_src = opnd;
        unique case (op)
            3'(OP_AND): begin
                result   = opnd & imm_ext;
                flag_src = result;
                stat_out[FLG_C] = 1'b0;
                stat_out[FLG_V] = 1'b0;
            end
            3'(OP_OR): begin
                result   = opnd | imm_ext;
                flag_src = result;
                stat_out[FLG_C] = 1'b0;
                stat_out[FLG_V] = 1'b0;
            end
            3'(OP_TST): begin
                we       = 1'b0;
                flag_src = opnd & imm_ext;
                stat_out[FLG_C] = 1'b0;
                stat_out[FLG_V] = 1'b0;
            end
            3'(OP_SRA): begin
                result   = sra_v;
                flag_src = sra_v;
                stat_out[FLG_C] = opnd[0];
            end
            3'(OP_SRL): begin
                result   = srl_v;
                flag_src = srl_v;
                stat_out[FLG_C] = opnd[0];
            end
            3'(OP_SLA): begin
                result   = sla_v;
                flag_src = sla_v;
            end
            default: begin
                we = 1'b0;
            end
        endcase
        stat_out[FLG_Z] = (flag_src == '0);
        stat_out[FLG_N] = flag_src[P_DATA_W-1];
    end
endmodule

// File: rtl/imm_alu_unit.sv
module imm_alu_unit
    import imm_alu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_op,
    input  logic [IDX_W+IMM_W-1:0]  in_insn,
    input  logic [DATA_W-1:0]       in_opnd,
    input  logic [STAT_W-1:0]       in_stat,
    output logic                    out_valid,
    output logic [IDX_W-1:0]        out_idx,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_we,
    output logic [STAT_W-1:0]       out_stat
);
    logic [IDX_W-1:0]  dec_idx;
    logic [IMM_W-1:0]  dec_imm;
    logic              dec_legal;
    logic [DATA_W-1:0] alu_res;
    logic              alu_we;
    logic [STAT_W-1:0] alu_stat;
    logic              accept;

    emit_state_e state_q, state_d;

    imm_alu_decode #(.P_IMM_W(IMM_W), .P_IDX_W(IDX_W)) u_dec (
        .insn   (in_insn),
        .op_raw (in_op),
        .idx    (dec_idx),
        .imm    (dec_imm),
        .legal  (dec_legal)
    );

    imm_alu_core #(.P_DATA_W(DATA_W), .P_IMM_W(IMM_W), .P_STAT_W(STAT_W)) u_core (
        .op       (in_op),
        .imm      (dec_imm),
        .opnd     (in_opnd),
        .stat_in  (in_stat),
        .result   (alu_res),
        .we       (alu_we),
        .stat_out (alu_stat)
    );

    assign accept = in_valid && dec_legal;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = accept ? S_EMIT : S_IDLE;
            S_EMIT: state_d = accept ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_idx  <= '0;
            out_data <= '0;
            out_we   <= 1'b0;
            out_stat <= '0;
        end else if (accept) begin
            out_idx  <= dec_idx;
            out_data <= alu_res;
            out_we   <= alu_we;
            out_stat <= alu_stat;
        end else begin
            out_we   <= 1'b0;
        end
    end

    assign out_valid = (state_q == S_EMIT);

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 3'd5) |=> out_valid);
    a_r10_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_op <= 3'd5)) |=> (!out_valid && !out_we));
    a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2) |=> (!out_we && out_data == $past(in_opnd)));
    a_r3_clear_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 3'd2) |=> (!out_stat[FLG_C] && !out_stat[FLG_V]));
    a_r6_keep_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5) |=> (out_stat[FLG_V:FLG_C] == $past(in_stat[FLG_V:FLG_C])));
    a_r5_carry_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 3'd3 || in_op == 3'd4)) |=>
        (out_stat[FLG_C] == $past(in_opnd[0]) && out_stat[FLG_V] == $past(in_stat[FLG_V])));
    a_r9_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= 3'd5) |=> (out_stat[STAT_W-1:4] == $past(in_stat[STAT_W-1:4])));
    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_we) |-> (out_stat[FLG_Z] == (out_data == '0)));
endmodule

// File: tb/imm_alu_unit_tb_top.sv
module imm_alu_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [9:0]  in_insn = '0;
    logic [31:0] in_opnd = '0;
    logic [7:0]  in_stat = '0;
    logic        out_valid;
    logic [1:0]  out_idx;
    logic [31:0] out_data;
    logic        out_we;
    logic [7:0]  out_stat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    imm_alu_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_insn(in_insn), .in_opnd(in_opnd), .in_stat(in_stat),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
        .out_we(out_we), .out_stat(out_stat)
    );

    function automatic logic [31:0] exp_data(input logic [2:0] op, input logic [7:0] imm,
                                             input logic [31:0] a);
        int n = imm;
        logic [31:0] r;
        case (op)
            3'd0: r = a & {24'h0, imm};
            3'd1: r = a | {24'h0, imm};
            3'd2: r = a;
            3'd3: begin
                r = a;
                for (int i = 0; i < n && i < 40; i++) r = {r[31], r[31:1]};
            end
            3'd4: r = (n >= 32) ? 32'h0 : a >> n;
            default: r = (n >= 32) ? 32'h0 : a << n;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] exp_stat(input logic [2:0] op, input logic [7:0] imm,
                                            input logic [31:0] a, input logic [7:0] s);
        logic [7:0] r = s;
        logic [31:0] f = (op == 3'd2) ? (a & {24'h0, imm}) : exp_data(op, imm, a);
        r[0] = (f == 32'h0);
        r[1] = f[31];
        if (op <= 3'd2) begin r[2] = 1'b0; r[3] = 1'b0; end
        else if (op != 3'd5) r[2] = a[0];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] op, input logic [1:0] idx,
                          input logic [7:0] imm, input logic [31:0] a, input logic [7:0] s);
        in_valid = 1'b1; in_op = op; in_insn = {idx, imm}; in_opnd = a; in_stat = s;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " idx R1"}, 64'(out_idx), 64'(idx));
        check({req, " data"}, 64'(out_data), 64'(exp_data(op, imm, a)));
        check({req, " we"}, 64'(out_we), 64'(op != 3'd2));
        check({req, " stat"}, 64'(out_stat), 64'(exp_stat(op, imm, a, s)));
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("reset R8 valid", 64'(out_valid), 64'd0);
        check("reset R8 we", 64'(out_we), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        run_op("R2 and", 3'd0, 2'd1, 8'h0F, 32'hFFFF_FF3C, 8'hFC);
        run_op("R3 and zero", 3'd0, 2'd2, 8'h00, 32'h8000_0000, 8'h0C);
        run_op("R2 or neg", 3'd1, 2'd3, 8'h81, 32'h8000_0000, 8'h5C);
        run_op("R4 test", 3'd2, 2'd0, 8'h80, 32'h1234_5680, 8'hAC);
        run_op("R4 test zero", 3'd2, 2'd1, 8'h01, 32'hFFFF_FFFE, 8'h0C);
        run_op("R5 sra", 3'd3, 2'd2, 8'd4, 32'h8000_00F1, 8'h08);
        run_op("R5 srl", 3'd4, 2'd2, 8'd4, 32'h8000_00F1, 8'h08);
        run_op("R7 sra 32", 3'd3, 2'd0, 8'd32, 32'h8000_0001, 8'h00);
        run_op("R7 sra 255", 3'd3, 2'd0, 8'd255, 32'h7FFF_FFFF, 8'h08);
        run_op("R7 srl 32", 3'd4, 2'd1, 8'd32, 32'hFFFF_FFFF, 8'h00);
        run_op("R7 srl 31", 3'd4, 2'd1, 8'd31, 32'hFFFF_FFFF, 8'h00);
        run_op("R7 sla 32", 3'd5, 2'd3, 8'd32, 32'hFFFF_FFFF, 8'h0C);
        run_op("R7 sra 0", 3'd3, 2'd3, 8'd0, 32'h0000_0001, 8'h08);
        run_op("R6 sla 0", 3'd5, 2'd3, 8'd0, 32'h8000_0001, 8'h0C);
        run_op("R6 sla", 3'd5, 2'd0, 8'd31, 32'h0000_0001, 8'h04);
        run_op("R9 upper", 3'd1, 2'd0, 8'h00, 32'h0, 8'hA5);
        // Illegal codes hold outputs
        held = out_data;
        for (int c = 6; c < 8; c++) begin
            in_valid = 1'b1; in_op = 3'(c); in_insn = 10'h3FF; in_opnd = 32'hDEAD_BEEF;
            @(negedge clk);
            in_valid = 1'b0;
            check("R10 valid", 64'(out_valid), 64'd0);
            check("R10 we", 64'(out_we), 64'd0);
            check("R10 data hold", 64'(out_data), 64'(held));
        end
        // Idle cycle after result
        @(negedge clk);
        check("R8 strobe single", 64'(out_valid), 64'd0);
        // Random back-to-back
        for (int k = 0; k < 400; k++) begin
            logic [7:0] imm;
            logic [2:0] op = 3'($urandom_range(0, 5));
            imm = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom);
            run_op("R8 random", op, 2'($urandom), imm, $urandom, 8'($urandom));
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule